// File: doc/BRIEF.md
# Precise Exception Tracker

This block follows every instruction of a four-stage front section of an in-order pipeline (fetch, decode, execute, memory) together with its fetch PC and a small exception tag. Each stage can report a fault on the instruction it currently holds. The fault is written into that instruction's tag, and the tag moves with the instruction. Nothing happens to the machine state when the fault is recorded. The exception is acted on only when the faulting instruction reaches the end of the memory stage. At that point the block raises a one-cycle flush of every younger stage, saves the instruction's PC and a cause code, and on the next cycle asks the fetch unit to load the trap vector.

Because faults are taken only at one point, and instructions reach that point in program order, the exception that is taken always belongs to the oldest faulting instruction. An external interrupt uses the same path. While the controller is idle and the request is high, the fetch slot is replaced by a no-op that already carries the interrupt cause. That no-op is taken when it reaches the end of the memory stage.

A small state machine controls the flow. Its states are RUN (normal flow), IRQ_WAIT (an interrupt no-op is in flight) and REDIRECT (the one cycle in which the vector is loaded). Its transitions are INJECT (RUN to IRQ_WAIT, when an interrupt no-op is inserted), TAKE (RUN or IRQ_WAIT to REDIRECT, when an exception commits) and RESUME (REDIRECT to RUN, always after one cycle).

Top module: `exc_tracker`

## Requirements
- R1: While reset is applied and on the first cycle after it: `epc_o` is 0, `cause_o` is 0, and `vec_load_o`, `flush_o`, `kill_o` and `retire_o` are all low.
- R2: A valid instruction with no fault drives `retire_o` high for one cycle while it is in the memory stage. That cycle is the third cycle after the cycle in which it was presented at fetch.
- R3: Bit k of `fault_i` reports a fault on the instruction in stage k. The stages are: 0 fetch (bad instruction address), 1 decode (undefined opcode), 2 execute (overflow), 3 memory (bad data address). Stage k holds the instruction that was fetched k cycles earlier. The cause code that is committed is k+1, and an interrupt no-op commits code 5.
- R4: An exception commits in the cycle its instruction is in the memory stage. On the next cycle `vec_load_o` is high for exactly one cycle, `vec_pc_o` equals the vector parameter, `epc_o` holds the instruction's fetch PC and `cause_o` holds its cause. `epc_o` changes at no other time.
- R5: In the commit cycle all three bits of `flush_o` are high. No younger instruction retires afterwards, and no younger instruction raises an exception afterwards.
- R6: If one instruction reports faults in more than one stage, the cause from the earliest stage is the one committed.
- R7: If several instructions in flight carry faults, only the oldest one is taken, even when a younger one reported its fault first.
- R8: Bit k of `kill_o` is high while the valid instruction in stage k carries a fault, whether the fault was recorded earlier or is raised in that cycle. A killed memory-stage instruction never retires.
- R9: While in RUN with `irq_i` high and no commit in progress, `irq_inject_o` is high for one cycle. The fetch slot becomes an interrupt no-op that carries `fetch_pc_i`. No further no-op is injected while that one is in flight.
- R10: An interrupt no-op that is flushed by an older exception is injected again once the controller returns to RUN, as long as `irq_i` is still high.
- R11: During the vector-load cycle the fetch inputs are ignored. An instruction presented then neither retires nor raises an exception.
- R12: Fault bits for stages that hold no valid instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | An instruction is present in the fetch stage |
| fetch_pc_i | input | PC_W | PC of the instruction in the fetch stage |
| fault_i | input | 4 | Per-stage fault report; bit k belongs to stage k |
| irq_i | input | 1 | External interrupt request, level |
| epc_o | output | PC_W | PC of the last instruction whose exception was taken |
| cause_o | output | 3 | Cause code of the last taken exception |
| vec_load_o | output | 1 | Load `vec_pc_o` into the PC this cycle |
| vec_pc_o | output | PC_W | Trap vector address |
| flush_o | output | 3 | Clear fetch, decode and execute stages |
| kill_o | output | 4 | Per-stage write disable for faulting instructions |
| retire_o | output | 1 | Memory-stage instruction leaves with its writes allowed |
| irq_inject_o | output | 1 | Replace the fetch slot by an interrupt no-op |

## Verification
The assertions assume that the pipeline around the block advances by one stage every cycle with no stalls. They also assume that each fault bit refers to the instruction the block itself is tracking in that stage. The stimulus follows both rules. It drives a new fetch slot on every clock and raises fault bit k only in the cycle when the targeted instruction, fetched k cycles earlier, sits in stage k. The interrupt request is a level that the bench drops once its no-op is in flight or has been taken, which matches how a handler would acknowledge it.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int N_STAGES = 4;
    localparam int CAUSE_W  = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_IADDR   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4,
        CAUSE_IRQ     = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_IRQ_WAIT = 2'd1,
        ST_REDIRECT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic   valid;
        cause_e cause;
    } tag_t;

endpackage

// File: rtl/exc_merge.sv
module exc_merge
    import exc_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CODE = 3'd0
) (
    input  tag_t in_tag,
    input  logic raise,
    output tag_t out_tag,
    output logic faulting
);

    // An earlier recorded cause always wins over a later stage's report.
    always_comb begin
        out_tag = in_tag;
        if (in_tag.valid && (in_tag.cause == CAUSE_NONE) && raise) begin
            out_tag.cause = cause_e'(CODE);
        end
        faulting = out_tag.valid && (out_tag.cause != CAUSE_NONE);
    end

endmodule

// File: rtl/exc_pipe_reg.sv
module exc_pipe_reg
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  tag_t            in_tag,
    input  logic [PC_W-1:0] in_pc,
    output tag_t            out_tag,
    output logic [PC_W-1:0] out_pc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tag <= '0;
            out_pc  <= '0;
        end else begin
            out_tag.valid <= in_tag.valid & ~flush;
            out_tag.cause <= in_tag.cause;
            out_pc        <= in_pc;
        end
    end

endmodule

// File: rtl/exc_commit_fsm.sv
module exc_commit_fsm
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_i,
    input  tag_t               mem_tag,
    input  logic [PC_W-1:0]    mem_pc,
    output logic               take_o,
    output logic               inject_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    ctl_state_e state_q, state_d;
    logic       commit;

    assign commit = mem_tag.valid && (mem_tag.cause != CAUSE_NONE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: INJECT, TAKE, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (commit) begin
                    state_d = ST_REDIRECT;
                end else if (irq_i) begin
                    state_d = ST_IRQ_WAIT;
                end
            end
            ST_IRQ_WAIT: begin
                if (commit) begin
                    state_d = ST_REDIRECT;
                end
            end
            ST_REDIRECT: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        take_o     = 1'b0;
        inject_o   = 1'b0;
        redirect_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                take_o   = commit;
                inject_o = irq_i && !commit;
            end
            ST_IRQ_WAIT: begin
                take_o = commit;
            end
            ST_REDIRECT: begin
                redirect_o = 1'b1;
            end
            default: begin
                take_o = 1'b0;
            end
        endcase
    end

    // Saved exception PC and cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= '0;
        end else if (take_o) begin
            epc_o   <= mem_pc;
            cause_o <= mem_tag.cause;
        end
    end

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
    import exc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_ADDR = 32'h0000_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid_i,
    input  logic [PC_W-1:0]     fetch_pc_i,
    input  logic [N_STAGES-1:0] fault_i,
    input  logic                irq_i,
    output logic [PC_W-1:0]     epc_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic                vec_load_o,
    output logic [PC_W-1:0]     vec_pc_o,
    output logic [N_STAGES-2:0] flush_o,
    output logic [N_STAGES-1:0] kill_o,
    output logic                retire_o,
    output logic                irq_inject_o
);

    localparam int LAST = N_STAGES - 1;

    tag_t            if_tag;
    tag_t            merged_tag [N_STAGES];
    tag_t            held_tag   [1:LAST];
    logic [PC_W-1:0] held_pc    [1:LAST];
    logic            take;
    logic            inject;
    logic            redirect;

    // Fetch slot: real instruction, interrupt no-op, or nothing while redirecting
    always_comb begin
        if_tag.valid = (fetch_valid_i | inject) & ~redirect;
        if_tag.cause = inject ? CAUSE_IRQ : CAUSE_NONE;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        tag_t            in_tag;
        logic [PC_W-1:0] in_pc;

        if (k == 0) begin : g_head
            assign in_tag = if_tag;
            assign in_pc  = fetch_pc_i;
        end else begin : g_body
            assign in_tag = held_tag[k];
            assign in_pc  = held_pc[k];
        end

        exc_merge #(
            .CODE(3'(k + 1))
        ) u_merge (
            .in_tag  (in_tag),
            .raise   (fault_i[k]),
            .out_tag (merged_tag[k]),
            .faulting(kill_o[k])
        );

        if (k < LAST) begin : g_reg
            exc_pipe_reg #(
                .PC_W(PC_W)
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .flush  (take),
                .in_tag (merged_tag[k]),
                .in_pc  (in_pc),
                .out_tag(held_tag[k+1]),
                .out_pc (held_pc[k+1])
            );
        end
    end

    exc_commit_fsm #(
        .PC_W(PC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .mem_tag   (merged_tag[LAST]),
        .mem_pc    (held_pc[LAST]),
        .take_o    (take),
        .inject_o  (inject),
        .redirect_o(redirect),
        .epc_o     (epc_o),
        .cause_o   (cause_o)
    );

    assign flush_o      = {(N_STAGES-1){take}};
    assign vec_load_o   = redirect;
    assign vec_pc_o     = VEC_ADDR;
    assign retire_o     = merged_tag[LAST].valid && !kill_o[LAST];
    assign irq_inject_o = inject;

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_load_o,
    input logic [2:0]      flush_o,
    input logic [3:0]      kill_o,
    input logic            retire_o,
    input logic            irq_inject_o,
    input logic [PC_W-1:0] epc_o,
    input logic [2:0]      cause_o
);

    p_vec_after_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o[0] |=> vec_load_o);

    p_vec_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load_o |=> !vec_load_o);

    p_epc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_load_o |-> $stable(epc_o));

    p_cause_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load_o |-> (cause_o != 3'd0 && cause_o <= 3'd5));

    p_flush_oldest_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o[0] |-> kill_o[3]);

    p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o[0] |-> (flush_o == 3'b111));

    p_killed_no_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o[3] |-> !retire_o);

    p_redirect_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load_o |-> (!retire_o && !irq_inject_o && kill_o == 4'b0000));

    p_after_redirect_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load_o |=> (!retire_o && !flush_o[0]));

    p_inject_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_inject_o |=> !irq_inject_o);

endmodule

bind exc_tracker exc_tracker_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_load_o  (vec_load_o),
    .flush_o     (flush_o),
    .kill_o      (kill_o),
    .retire_o    (retire_o),
    .irq_inject_o(irq_inject_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o)
);

// File: tb/exc_tracker_tb.sv
module exc_tracker_tb;

    localparam int          PC_W = 32;
    localparam logic [31:0] VEC  = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic [3:0]  fault_i = '0;
    logic        irq_i = 1'b0;
    logic [31:0] epc_o;
    logic [2:0]  cause_o;
    logic        vec_load_o;
    logic [31:0] vec_pc_o;
    logic [2:0]  flush_o;
    logic [3:0]  kill_o;
    logic        retire_o;
    logic        irq_inject_o;

    always #10 clk = ~clk;

    exc_tracker #(.PC_W(PC_W), .VEC_ADDR(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i),
        .fetch_pc_i(fetch_pc_i), .fault_i(fault_i), .irq_i(irq_i),
        .epc_o(epc_o), .cause_o(cause_o), .vec_load_o(vec_load_o),
        .vec_pc_o(vec_pc_o), .flush_o(flush_o), .kill_o(kill_o),
        .retire_o(retire_o), .irq_inject_o(irq_inject_o)
    );

    int checks = 0;
    int failures = 0;
    int ret_cnt = 0;
    int vec_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] epc;
        logic [2:0]  cause;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    // Snapshot of the outputs of the last stepped cycle
    logic [31:0] s_epc;
    logic [2:0]  s_cause;
    logic        s_vec, s_retire, s_inject;
    logic [2:0]  s_flush;
    logic [3:0]  s_kill;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] p,
                        input logic [3:0] f, input logic q);
        fetch_valid_i = v;
        fetch_pc_i    = p;
        fault_i       = f;
        irq_i         = q;
        @(negedge clk);
        s_epc = epc_o; s_cause = cause_o; s_vec = vec_load_o;
        s_retire = retire_o; s_inject = irq_inject_o;
        s_flush = flush_o; s_kill = kill_o;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic expect_trap(input logic [31:0] pc, input logic [2:0] c, input string req);
        exp_t e;
        e.epc = pc; e.cause = c; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: scoreboard pop on each vector load, retire counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (retire_o) ret_cnt++;
            if (vec_load_o) begin
                vec_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7/R12", "unexpected vector load epc", epc_o, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(epc_o == e.epc, e.req, "epc", epc_o, e.epc);
                    check(cause_o == e.cause, e.req, "cause", {29'd0, cause_o}, {29'd0, e.cause});
                    check(vec_pc_o == VEC, "R4", "vector pc", vec_pc_o, VEC);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(epc_o == 0 && cause_o == 0, "R1", "epc/cause in reset", {epc_o[28:0], cause_o}, 0);
        check(!vec_load_o && flush_o == 0 && kill_o == 0 && !retire_o, "R1", "controls in reset",
              {vec_load_o, flush_o, kill_o, retire_o}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(1);
        check(s_epc == 0 && s_cause == 0 && !s_vec && s_flush == 0, "R1", "after reset",
              {s_epc[27:0], s_cause, s_vec}, 0);

        // R2: clean instructions retire in the third cycle after fetch
        begin
            int r0;
            r0 = ret_cnt;
            step(1'b1, 32'h100, 4'h0, 1'b0);
            step(1'b1, 32'h104, 4'h0, 1'b0);
            step(1'b1, 32'h108, 4'h0, 1'b0);
            step(1'b0, 32'h0,   4'h0, 1'b0);
            check(s_retire == 1'b1, "R2", "retire in memory stage", s_retire, 1);
            idle(4);
            check(ret_cnt - r0 == 3, "R2", "retire count", ret_cnt - r0, 3);
        end

        // R3/R4/R5/R8/R11: overflow on the oldest of three
        begin
            int r0;
            r0 = ret_cnt;
            expect_trap(32'h200, 3'd3, "R3");
            step(1'b1, 32'h200, 4'h0, 1'b0);
            step(1'b1, 32'h204, 4'h0, 1'b0);
            step(1'b1, 32'h208, 4'b0100, 1'b0);
            check(s_kill == 4'b0100, "R8", "kill at execute", s_kill, 4'b0100);
            step(1'b0, 32'h0, 4'h0, 1'b0);
            check(s_flush == 3'b111, "R5", "flush on commit", s_flush, 3'b111);
            check(s_kill[3] && !s_retire, "R8", "memory kill, no retire", {s_kill[3], s_retire}, 2'b10);
            check(!s_vec, "R4", "no vector in commit cycle", s_vec, 0);
            step(1'b1, 32'h20C, 4'h0, 1'b0);   // R11: ignored during redirect
            check(s_vec, "R4", "vector load after commit", s_vec, 1);
            check(s_epc == 32'h200 && s_cause == 3'd3, "R4", "epc/cause", s_epc, 32'h200);
            step(1'b0, 32'h0, 4'h0, 1'b0);
            check(!s_vec, "R4", "vector load one cycle", s_vec, 0);
            idle(4);
            check(ret_cnt == r0, "R5", "younger and redirect-cycle fetch do not retire", ret_cnt - r0, 0);
            check(s_epc == 32'h200, "R4", "epc held", s_epc, 32'h200);
        end

        // R6: fetch fault then overflow on the same instruction
        expect_trap(32'h300, 3'd1, "R6");
        step(1'b1, 32'h300, 4'b0001, 1'b0);
        step(1'b0, 32'h0, 4'h0, 1'b0);
        step(1'b0, 32'h0, 4'b0100, 1'b0);
        idle(6);

        // R7: older data fault beats younger fetch fault raised earlier
        expect_trap(32'h500, 3'd4, "R7");
        step(1'b1, 32'h500, 4'h0, 1'b0);
        step(1'b1, 32'h504, 4'b0001, 1'b0);
        step(1'b1, 32'h508, 4'b0010, 1'b0);
        step(1'b0, 32'h0, 4'b1000, 1'b0);
        idle(6);

        // R9: interrupt injected as a no-op with the fetch PC
        begin
            int r0;
            r0 = ret_cnt;
            expect_trap(32'h600, 3'd5, "R9");
            step(1'b1, 32'h600, 4'h0, 1'b1);
            check(s_inject, "R9", "inject", s_inject, 1);
            step(1'b1, 32'h604, 4'h0, 1'b1);
            check(!s_inject, "R9", "single no-op in flight", s_inject, 0);
            step(1'b1, 32'h608, 4'h0, 1'b0);
            step(1'b0, 32'h0, 4'h0, 1'b0);
            idle(4);
            check(ret_cnt == r0, "R9", "instructions behind no-op flushed", ret_cnt - r0, 0);
        end

        // R10/R11: no-op flushed by older overflow, then re-injected
        expect_trap(32'h700, 3'd3, "R10");
        expect_trap(32'h080, 3'd5, "R10");
        step(1'b1, 32'h700, 4'h0, 1'b0);
        step(1'b1, 32'h704, 4'h0, 1'b1);
        check(s_inject, "R10", "first inject", s_inject, 1);
        step(1'b1, 32'h708, 4'b0100, 1'b1);
        step(1'b0, 32'h0, 4'h0, 1'b1);
        step(1'b1, 32'h999, 4'b0001, 1'b1);
        check(!s_inject, "R11", "no inject during redirect", s_inject, 0);
        step(1'b1, 32'h080, 4'h0, 1'b1);
        check(s_inject, "R10", "re-inject after resume", s_inject, 1);
        idle(8);

        // R12: faults on empty stages
        begin
            int v0;
            v0 = vec_cnt;
            for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 4'b1111, 1'b0);
            check(s_kill == 4'b0000, "R12", "no kill on empty stages", s_kill, 0);
            idle(5);
            check(vec_cnt == v0, "R12", "no vector load", vec_cnt - v0, 0);
        end

        check(exp_q.size() == 0, "R4", "pending expected traps", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule